// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Port

The block is a full-duplex asynchronous serial port whose transmitter and receiver run independently but share one 13-bit divisor. A clock enable fires once every `baud_div` system clocks, and each line bit lasts sixteen of those enables. The bit rate is therefore clk / (16 × `baud_div`). With a 24 MHz clock and a divisor of 156, this comes to about 9615 baud.

On the transmit side the host writes a byte into a holding register. As soon as the shifter is free, the holding register hands the byte over. The shifter sends a low start bit, the eight data bits least significant first, and a high stop bit. The holding register is free again to take the next byte while the frame is on the line.

On the receive side the line passes through a two-flop synchroniser. The start bit is confirmed at its mid-point, and each data bit is sampled at its centre. A completed byte is copied into a read register at once. The host sees a receive-full flag and two sticky error flags: a framing error (bad stop bit) and an overrun (byte lost because the read register was still unread).

Top module: `uart_dbuf`

## Requirements
- R1: While and after reset, `txd` is 1, `tx_empty` is 1, and `rx_full`, `frame_err` and `overrun` are 0.
- R2: A transmitted frame has ten bits: a start bit at 0, then data bits 0 to 7 in that order, then a stop bit at 1. For the byte 0x2D the eight data bits appear on `txd` as 1,0,1,1,0,1,0,0 in time order.
- R3: One bit lasts 16 × `baud_div` clocks for both directions; a divisor of 0 acts as 1. For the byte 0x00, `txd` stays low for between 143 × BR + 1 and 144 × BR clocks (start bit plus eight zero bits). With a divisor of 0 it stays low for exactly 144 clocks. `txd` only rises on a divider tick.
- R4: A write with `tx_empty` = 1 clears `tx_empty` from the next cycle on. If the shifter is idle, the byte moves into it one cycle later and `tx_empty` returns to 1. If the shifter is busy, `tx_empty` stays 0 until the current frame's stop bit ends.
- R5: A write while `tx_empty` = 0 is discarded and produces no frame.
- R6: A frame received with a high stop bit sets `rx_full`, and `rd_data` shows its byte. The first serial data bit lands in bit 0.
- R7: A one-cycle `rd_en` pulse clears `rx_full` when no byte completes in the same cycle.
- R8: A stop bit sampled as 0 sets `frame_err`. Such a frame changes neither `rd_data` nor `rx_full`.
- R9: A byte that completes while `rx_full` = 1 and `rd_en` = 0 sets `overrun`. `rd_data` keeps the older byte and `rx_full` stays 1.
- R10: If `rd_en` is high in the very cycle a byte completes, the new byte is stored, `rx_full` stays 1 and `overrun` stays 0.
- R11: A low pulse on `rxd` that has ended before the start-bit mid-point is ignored. No byte is stored and no flag is set, and a later valid frame is still received.
- R12: `rd_en` clears `frame_err` and `overrun`; both stay set until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_div | input | 13 | Divisor BR; bit time is 16 × BR clocks (0 acts as 1) |
| wr_en | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Holding register can take a byte |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rd_en | input | 1 | Read strobe: clears receive-full and error flags |
| rd_data | output | 8 | Last byte received |
| rx_full | output | 1 | Read register holds an unread byte |
| frame_err | output | 1 | Sticky: a stop bit was sampled low |
| overrun | output | 1 | Sticky: a byte was dropped because the read register was unread |

## Verification
Two receive-side functions can fall in the same clock: the host's read strobe, and the hand-off of a just-completed byte into the read register. The bench provokes this case in three steps:
1. It starts every receive frame at the same phase of the free-running divider, so the hand-off cycle repeats exactly from frame to frame.
2. It measures that cycle on a frame received into an empty register.
3. On a later frame, sent while the register still holds an unread byte, it raises `rd_en` for just that cycle.

The case is judged correct when `rx_full` stays set, `rd_data` holds the new byte and no overrun is flagged, in contrast to the plain overrun case where the same frame without a read keeps the old byte.

// File: rtl/uart_dbuf_pkg.sv
package uart_dbuf_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_dbuf_baud.sv
// Free-running divider: one tick every max(div,1) clocks.
module uart_dbuf_baud #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = (div == '0) ? '0 : div - ONE;
    tick  = (cnt_q >= lim);
    cnt_d = tick ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_dbuf_tx.sv
// Transmit holding register plus framing shifter.
module uart_dbuf_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_empty,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int TCNT_W  = $clog2(OSR);
  localparam int BCNT_W  = $clog2(FRAME_W);
  localparam logic [TCNT_W-1:0] T_LAST = TCNT_W'(OSR - 1);
  localparam logic [BCNT_W-1:0] B_LAST = BCNT_W'(FRAME_W - 1);

  logic [DATA_W-1:0]  hold_q, hold_d;
  logic               hold_v_q, hold_v_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               busy_q, busy_d;
  logic [TCNT_W-1:0]  tcnt_q, tcnt_d;
  logic [BCNT_W-1:0]  bcnt_q, bcnt_d;
  logic               take;
  logic               accept;

  always_comb begin
    hold_d   = hold_q;
    hold_v_d = hold_v_q;
    sh_d     = sh_q;
    busy_d   = busy_q;
    tcnt_d   = tcnt_q;
    bcnt_d   = bcnt_q;
    accept   = wr_en && !hold_v_q;
    take     = hold_v_q && !busy_q;

    if (accept) begin
      hold_d   = wr_data;
      hold_v_d = 1'b1;
    end

    if (take) begin
      hold_v_d = 1'b0;
      sh_d     = {1'b1, hold_q, 1'b0};
      busy_d   = 1'b1;
      tcnt_d   = '0;
      bcnt_d   = '0;
    end else if (busy_q && tick) begin
      if (tcnt_q == T_LAST) begin
        tcnt_d = '0;
        sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
        if (bcnt_q == B_LAST) begin
          busy_d = 1'b0;
          bcnt_d = '0;
        end else begin
          bcnt_d = bcnt_q + BCNT_W'(1);
        end
      end else begin
        tcnt_d = tcnt_q + TCNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      hold_v_q <= 1'b0;
      sh_q     <= '1;
      busy_q   <= 1'b0;
      tcnt_q   <= '0;
      bcnt_q   <= '0;
    end else begin
      hold_q   <= hold_d;
      hold_v_q <= hold_v_d;
      sh_q     <= sh_d;
      busy_q   <= busy_d;
      tcnt_q   <= tcnt_d;
      bcnt_q   <= bcnt_d;
    end
  end

  assign tx_empty = !hold_v_q;
  assign txd      = sh_q[0];
endmodule

// File: rtl/uart_dbuf_rx.sv
// Receive synchroniser, mid-bit sampler, read register and error flags.
module uart_dbuf_rx
  import uart_dbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_full,
  output logic              frame_err,
  output logic              overrun
);
  localparam int TCNT_W = $clog2(OSR);
  localparam int BCNT_W = $clog2(DATA_W);
  localparam logic [TCNT_W-1:0] T_LAST = TCNT_W'(OSR - 1);
  localparam logic [TCNT_W-1:0] T_MID  = TCNT_W'(OSR / 2 - 1);
  localparam logic [BCNT_W-1:0] B_LAST = BCNT_W'(DATA_W - 1);

  logic              s1_q, s2_q, prev_q;
  rx_state_e         st_q, st_d;
  logic [TCNT_W-1:0] tcnt_q, tcnt_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] dr_q, dr_d;
  logic              full_q, full_d;
  logic              fe_q, fe_d;
  logic              ov_q, ov_d;
  logic              load, fe_set, ov_set;

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    bcnt_d = bcnt_q;
    sh_d   = sh_q;
    load   = 1'b0;
    fe_set = 1'b0;
    ov_set = 1'b0;

    unique case (st_q)
      RX_IDLE: begin
        if (prev_q && !s2_q) begin
          st_d   = RX_START;
          tcnt_d = '0;
        end
      end
      RX_START: begin
        if (tick) begin
          if (tcnt_q == T_MID) begin
            tcnt_d = '0;
            bcnt_d = '0;
            st_d   = s2_q ? RX_IDLE : RX_DATA;
          end else begin
            tcnt_d = tcnt_q + TCNT_W'(1);
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          if (tcnt_q == T_LAST) begin
            tcnt_d = '0;
            sh_d   = {s2_q, sh_q[DATA_W-1:1]};
            if (bcnt_q == B_LAST) st_d = RX_STOP;
            else                  bcnt_d = bcnt_q + BCNT_W'(1);
          end else begin
            tcnt_d = tcnt_q + TCNT_W'(1);
          end
        end
      end
      RX_STOP: begin
        if (tick) begin
          if (tcnt_q == T_LAST) begin
            tcnt_d = '0;
            st_d   = RX_IDLE;
            if (!s2_q)                 fe_set = 1'b1;
            else if (full_q && !rd_en) ov_set = 1'b1;
            else                       load   = 1'b1;
          end else begin
            tcnt_d = tcnt_q + TCNT_W'(1);
          end
        end
      end
      default: st_d = RX_IDLE;
    endcase

    dr_d   = load ? sh_q : dr_q;
    full_d = load | (full_q & ~rd_en);
    fe_d   = fe_set | (fe_q & ~rd_en);
    ov_d   = ov_set | (ov_q & ~rd_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      st_q   <= RX_IDLE;
      tcnt_q <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
      dr_q   <= '0;
      full_q <= 1'b0;
      fe_q   <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      s1_q   <= rxd;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      bcnt_q <= bcnt_d;
      sh_q   <= sh_d;
      dr_q   <= dr_d;
      full_q <= full_d;
      fe_q   <= fe_d;
      ov_q   <= ov_d;
    end
  end

  assign rd_data   = dr_q;
  assign rx_full   = full_q;
  assign frame_err = fe_q;
  assign overrun   = ov_q;
endmodule

// File: rtl/uart_dbuf.sv
// Top: reset synchroniser, shared divider, transmitter and receiver.
module uart_dbuf #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 13,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_empty,
  output logic              txd,
  input  logic              rxd,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_full,
  output logic              frame_err,
  output logic              overrun
);
  logic [1:0] rs_q;
  logic       rst_i_n;
  logic       tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  uart_dbuf_baud #(.DIV_W(DIV_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_i_n),
    .div   (baud_div),
    .tick  (tick)
  );

  uart_dbuf_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .tick     (tick),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .tx_empty (tx_empty),
    .txd      (txd)
  );

  uart_dbuf_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .tick      (tick),
    .rxd       (rxd),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rx_full   (rx_full),
    .frame_err (frame_err),
    .overrun   (overrun)
  );
endmodule

// File: rtl/uart_dbuf_chk.sv
module uart_dbuf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic              tx_empty,
  input logic              txd,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rx_full,
  input logic              frame_err,
  input logic              overrun
);
  AST_EMPTY_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_en && tx_empty |=> !tx_empty); // R4
  AST_TXD_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) $rose(txd) |-> $past(tick)); // R3
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) rx_full && !rd_en |=> $stable(rd_data)); // R9
  AST_OVR_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n) $rose(overrun) |-> rx_full && $past(rx_full)); // R9
  AST_FE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n) $rose(frame_err) && !$past(rd_en) |-> rx_full == $past(rx_full)); // R8
endmodule

bind uart_dbuf uart_dbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .wr_en     (wr_en),
  .tx_empty  (tx_empty),
  .txd       (txd),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .rx_full   (rx_full),
  .frame_err (frame_err),
  .overrun   (overrun)
);

// File: tb/tb_uart_dbuf.sv
module tb_uart_dbuf;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] baud_div;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic        tx_empty, txd;
  logic        rxd, rd_en;
  logic [7:0]  rd_data;
  logic        rx_full, frame_err, overrun;

  int n_chk = 0;
  int n_bad = 0;
  int br    = 4;
  int cyc;
  int f_start;
  bit f_started;
  int c_full;
  int hand_d;

  uart_dbuf dut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .wr_en(wr_en),
    .wr_data(wr_data), .tx_empty(tx_empty), .txd(txd), .rxd(rxd),
    .rd_en(rd_en), .rd_data(rd_data), .rx_full(rx_full),
    .frame_err(frame_err), .overrun(overrun)
  );

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // Line-level reference receiver for txd: samples each bit at its centre.
  task automatic tx_capture(input logic [7:0] exp, input bit seq_chk);
    logic [9:0] bits;
    logic [7:0] seq;
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    repeat (8 * br) @(negedge clk);
    bits[0] = txd;
    for (int k = 1; k < 10; k++) begin
      repeat (16 * br) @(negedge clk);
      bits[k] = txd;
    end
    for (int k = 0; k < 8; k++) seq[7-k] = bits[k+1];
    check("R2", "start bit", int'(bits[0]), 0);
    check("R2", "data byte", int'(bits[8:1]), int'(exp));
    check("R2", "stop bit", int'(bits[9]), 1);
    if (seq_chk) check("R2", "time-ordered bits of 0x2D", int'(seq), 8'hB4);
  endtask

  // Bench driver for rxd, always started at the same divider phase.
  task automatic rx_send(input logic [7:0] b, input logic stopv);
    @(negedge clk);
    while ((cyc % br) != 0) @(negedge clk);
    f_start   = cyc;
    f_started = 1'b1;
    rxd = 1'b0;
    repeat (16 * br) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (16 * br) @(negedge clk);
    end
    rxd = stopv;
    repeat (16 * br) @(negedge clk);
    rxd = 1'b1;
    repeat (16 * br) @(negedge clk);
  endtask

  task automatic read_pulse();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic low_len(input logic [7:0] b, output int len);
    int t0;
    @(negedge clk);
    wr_data = b;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
    while (txd !== 1'b1) @(negedge clk);
    len = cyc - t0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int len;
    int lows;
    rst_n = 1'b0; baud_div = 13'd4; wr_en = 1'b0; wr_data = 8'h00;
    rxd = 1'b1; rd_en = 1'b0; f_started = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "txd in reset", int'(txd), 1);
    check("R1", "tx_empty in reset", int'(tx_empty), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", "txd after reset", int'(txd), 1);
    check("R1", "tx_empty after reset", int'(tx_empty), 1);
    check("R1", "rx_full after reset", int'(rx_full), 0);
    check("R1", "frame_err after reset", int'(frame_err), 0);
    check("R1", "overrun after reset", int'(overrun), 0);

    // R2 / R4 / R5: two writes back to back, third write while full dropped
    fork
      begin
        tx_capture(8'h2D, 1'b1);
        tx_capture(8'hA5, 1'b0);
      end
      begin
        wr_data = 8'h2D; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R4", "tx_empty after write", int'(tx_empty), 0);
        @(negedge clk);
        check("R4", "tx_empty after hand-off", int'(tx_empty), 1);
        wr_data = 8'hA5; wr_en = 1'b1;
        @(negedge clk);
        check("R4", "tx_empty while shifter busy", int'(tx_empty), 0);
        wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0;
        check("R5", "tx_empty after dropped write", int'(tx_empty), 0);
      end
    join
    lows = 0;
    repeat (320 * br) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    check("R5", "low cycles after discarded write", lows, 0);
    check("R4", "tx_empty once queue drained", int'(tx_empty), 1);

    // R3: bit time at BR=4
    low_len(8'h00, len);
    check("R3", "low span of 0x00 in range", int'(len >= 143 * br + 1 && len <= 144 * br), 1);
    repeat (40 * br) @(negedge clk);

    // R6 / R7: plain receive, measure hand-off offset
    f_started = 1'b0;
    fork
      rx_send(8'h2D, 1'b1);
      begin
        @(negedge clk);
        while (rx_full !== 1'b1) @(negedge clk);
        c_full = cyc;
      end
    join
    hand_d = c_full - f_start;
    check("R6", "rx_full after frame", int'(rx_full), 1);
    check("R6", "rd_data", int'(rd_data), 8'h2D);
    check("R6", "no frame_err", int'(frame_err), 0);
    read_pulse();
    check("R7", "rx_full after read", int'(rx_full), 0);

    // R9 / R12: overrun keeps older byte
    rx_send(8'h5A, 1'b1);
    check("R9", "rx_full first byte", int'(rx_full), 1);
    rx_send(8'hC3, 1'b1);
    check("R9", "overrun set", int'(overrun), 1);
    check("R9", "old byte kept", int'(rd_data), 8'h5A);
    check("R9", "rx_full kept", int'(rx_full), 1);
    read_pulse();
    check("R12", "overrun cleared by read", int'(overrun), 0);
    check("R7", "rx_full cleared by read", int'(rx_full), 0);

    // R10: read in the same cycle as hand-off
    rx_send(8'h11, 1'b1);
    f_started = 1'b0;
    fork
      rx_send(8'h99, 1'b1);
      begin
        @(negedge clk);
        while (!(f_started && cyc == f_start + hand_d - 1)) @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
      end
    join
    check("R10", "rx_full after coincident read", int'(rx_full), 1);
    check("R10", "new byte stored", int'(rd_data), 8'h99);
    check("R10", "no overrun", int'(overrun), 0);
    read_pulse();

    // R8 / R12: framing error
    rx_send(8'h3C, 1'b0);
    check("R8", "frame_err set", int'(frame_err), 1);
    check("R8", "rx_full unchanged", int'(rx_full), 0);
    check("R8", "rd_data unchanged", int'(rd_data), 8'h99);
    repeat (20 * br) @(negedge clk);
    check("R12", "frame_err sticky", int'(frame_err), 1);
    read_pulse();
    check("R12", "frame_err cleared by read", int'(frame_err), 0);

    // R11: short low pulse
    @(negedge clk);
    rxd = 1'b0;
    repeat (3 * br) @(negedge clk);
    rxd = 1'b1;
    repeat (320 * br) @(negedge clk);
    check("R11", "no byte from glitch", int'(rx_full), 0);
    check("R11", "no frame_err from glitch", int'(frame_err), 0);
    rx_send(8'hE7, 1'b1);
    check("R11", "receiver still works", int'(rd_data), 8'hE7);
    check("R11", "rx_full after valid frame", int'(rx_full), 1);
    read_pulse();

    // R3: divisor 0 behaves as 1
    baud_div = 13'd0;
    br = 1;
    repeat (20) @(negedge clk);
    low_len(8'h00, len);
    check("R3", "low span at divisor 0", len, 144);
    repeat (200) @(negedge clk);

    report();
    $finish;
  end
endmodule